// File: doc/BRIEF.md
# Double-Edge Input Capture Register

This block samples an input bus on both edges of its clock and hands the two samples to the core as a pair that changes only on the rising edge. A holding register clocked on the falling edge keeps the mid-cycle sample. At the next rising edge, that held sample goes to the falling-sample output and the live input goes to the rising-sample output. Logic downstream therefore sees both halves of a double-data-rate bit period in one rising-edge clock domain.

Two load paths override normal capture, and each forces a value fixed at elaboration. The active-low asynchronous load drives both outputs at once to the inverse of `ASYNC_DATA`, whatever the clock is doing. The active-low synchronous load puts `SYNC_DATA` on both outputs at an enabled rising edge. A clock enable freezes the output pair. The holding stage keeps sampling on every falling edge whatever the enable is, and the asynchronous load does not clear it.

Top module: `ddr_in_capture`

## Requirements
- R1: At a rising edge with `en` = 1, `sload_n` = 1 and `aload_n` = 1, `q_rise` takes the value `din` has at that edge.
- R2: At the same kind of edge, `q_fall` takes the value `din` had at the falling edge just before it.
- R3: While `aload_n` = 0, both outputs equal the inverse of `ASYNC_DATA`, and they take that value as soon as `aload_n` goes low, with no clock edge needed.
- R4: At a rising edge with `en` = 1, `sload_n` = 0 and `aload_n` = 1, both outputs take `SYNC_DATA`.
- R5: At a rising edge with `en` = 0, both outputs keep their values, and a low `sload_n` has no effect.
- R6: The asynchronous load wins over the synchronous load, the enable and the clock. While it is held, rising edges with `en` = 1 and `sload_n` at either level leave the outputs forced.
- R7: After `aload_n` returns high, the first enabled rising edge captures normally. The falling sample comes from the holding stage, which the asynchronous load did not clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock; both edges are used |
| din | input | LANES | Data to capture |
| en | input | 1 | Rising-edge enable, active high |
| sload_n | input | 1 | Synchronous load, active low |
| aload_n | input | 1 | Asynchronous load, active low |
| q_rise | output | LANES | Sample taken at the rising edge |
| q_fall | output | LANES | Sample taken at the preceding falling edge, retimed |

## Verification
The clocked assertions assume that `en`, `sload_n` and `aload_n` change only between edges, and that `aload_n` does not pulse low and return high inside one clock period. Under either violation the forced value would stand where a capture is expected. The stimulus drives every control and the rising-edge data just after a falling edge. It drives the falling-edge data just after a rising edge. The asynchronous load is asserted and released only at these points, and it is held for whole cycles. The bench starts with `aload_n` high and pulls it low within the first nanosecond, so the load takes effect through a real transition.

// File: rtl/ddr_cap_pkg.sv
`timescale 1ns/1ps
package ddr_cap_pkg;

  // Next value of a rising-edge output register outside asynchronous load.
  function automatic logic next_sample(input logic en, input logic sload_n,
                                       input logic sync_v, input logic fresh,
                                       input logic cur);
    if (!en)           return cur;
    else if (!sload_n) return sync_v;
    else               return fresh;
  endfunction

  function automatic bit is_binary(input int v);
    return (v == 0) || (v == 1);
  endfunction

endpackage

// File: rtl/ddr_cap_neg_hold.sv
`timescale 1ns/1ps
module ddr_cap_neg_hold #(
  parameter int LANES = 1
) (
  input  logic             clk,
  input  logic [LANES-1:0] din,
  output logic [LANES-1:0] held
);
  // Falling-edge holding stage: no enable gating, no load.
  always_ff @(negedge clk) begin
    held <= din;
  end
endmodule

// File: rtl/ddr_cap_pos_pair.sv
`timescale 1ns/1ps
module ddr_cap_pos_pair
  import ddr_cap_pkg::*;
#(
  parameter int LANES      = 1,
  parameter int ASYNC_DATA = 0,
  parameter int SYNC_DATA  = 0
) (
  input  logic             clk,
  input  logic             en,
  input  logic             sload_n,
  input  logic             aload_n,
  input  logic [LANES-1:0] din,
  input  logic [LANES-1:0] held,
  output logic [LANES-1:0] q_rise,
  output logic [LANES-1:0] q_fall
);
  localparam logic [LANES-1:0] FORCE_V = (ASYNC_DATA != 0) ? '0 : '1;
  localparam logic             SYNC_B  = (SYNC_DATA != 0);
  localparam logic [LANES-1:0] SYNC_V  = SYNC_B ? '1 : '0;

  logic             load_fire;
  logic             cap_fire;
  logic [LANES-1:0] nxt_rise;
  logic [LANES-1:0] nxt_fall;

  assign load_fire = en & ~sload_n;
  assign cap_fire  = en & sload_n;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign nxt_rise[i] = next_sample(en, sload_n, SYNC_B, din[i],  q_rise[i]);
    assign nxt_fall[i] = next_sample(en, sload_n, SYNC_B, held[i], q_fall[i]);

    always_ff @(posedge clk or negedge aload_n) begin
      if (!aload_n) begin
        q_rise[i] <= FORCE_V[i];
        q_fall[i] <= FORCE_V[i];
      end else begin
        q_rise[i] <= nxt_rise[i];
        q_fall[i] <= nxt_fall[i];
      end
    end
  end

  assert_rise_capture_R1: assert property (@(posedge clk) disable iff (!aload_n)
    cap_fire |=> q_rise == $past(din));
  assert_fall_retime_R2: assert property (@(posedge clk) disable iff (!aload_n)
    cap_fire |=> q_fall == $past(held));
  assert_async_force_R3: assert property (@(negedge clk)
    !aload_n |-> (q_rise == FORCE_V && q_fall == FORCE_V));
  assert_sync_load_R4: assert property (@(posedge clk) disable iff (!aload_n)
    load_fire |=> (q_rise == SYNC_V && q_fall == SYNC_V));
  assert_hold_R5: assert property (@(posedge clk) disable iff (!aload_n)
    !en |=> ($stable(q_rise) && $stable(q_fall)));
  assert_async_priority_R6: assert property (@(posedge clk)
    !aload_n |-> (q_rise == FORCE_V && q_fall == FORCE_V));
endmodule

// File: rtl/ddr_in_capture.sv
`timescale 1ns/1ps
module ddr_in_capture
  import ddr_cap_pkg::*;
#(
  parameter int LANES      = 1,
  parameter int ASYNC_DATA = 0,
  parameter int SYNC_DATA  = 0
) (
  input  logic             clk,
  input  logic [LANES-1:0] din,
  input  logic             en,
  input  logic             sload_n,
  input  logic             aload_n,
  output logic [LANES-1:0] q_rise,
  output logic [LANES-1:0] q_fall
);
  if (!is_binary(ASYNC_DATA)) begin : g_bad_async
    $error("ASYNC_DATA must be 0 or 1");
  end
  if (!is_binary(SYNC_DATA)) begin : g_bad_sync
    $error("SYNC_DATA must be 0 or 1");
  end

  logic [LANES-1:0] held;

  ddr_cap_neg_hold #(.LANES(LANES)) u_hold (
    .clk  (clk),
    .din  (din),
    .held (held)
  );

  ddr_cap_pos_pair #(
    .LANES      (LANES),
    .ASYNC_DATA (ASYNC_DATA),
    .SYNC_DATA  (SYNC_DATA)
  ) u_pair (
    .clk     (clk),
    .en      (en),
    .sload_n (sload_n),
    .aload_n (aload_n),
    .din     (din),
    .held    (held),
    .q_rise  (q_rise),
    .q_fall  (q_fall)
  );
endmodule

// File: tb/ddr_in_capture_tb_top.sv
`timescale 1ns/1ps
module ddr_in_capture_tb_top;
  localparam int AD = 0;
  localparam int SD = 0;
  localparam logic FRC = (AD != 0) ? 1'b0 : 1'b1;
  localparam logic SLV = (SD != 0);

  typedef struct {
    logic  r;
    logic  f;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic [0:0] din = 1'b0;
  logic en = 1'b0;
  logic sload_n = 1'b1;
  logic aload_n = 1'b1;
  logic [0:0] q_rise;
  logic [0:0] q_fall;

  int total = 0;
  int bad = 0;
  bit done = 0;
  exp_t sb[$];
  logic mr = 1'b0, mf = 1'b0;

  always #2 clk = ~clk;

  ddr_in_capture #(.LANES(1), .ASYNC_DATA(AD), .SYNC_DATA(SD)) dut_i (
    .clk(clk), .din(din), .en(en), .sload_n(sload_n), .aload_n(aload_n),
    .q_rise(q_rise), .q_fall(q_fall)
  );

  task automatic check(input string tag, input logic ar, input logic af,
                       input logic er, input logic ef);
    total++;
    if (ar !== er || af !== ef) begin
      bad++;
      $display("FAIL %s: got rise=%b fall=%b, expected rise=%b fall=%b",
               tag, ar, af, er, ef);
    end
  endtask

  // One clock period: fall-edge data first, then rise-edge data and controls.
  task automatic cyc(input logic r, input logic f, input logic e,
                     input logic sl, input logic al, input string tag);
    exp_t it;
    @(posedge clk); #1;
    din = f;
    @(negedge clk); #1;
    din = r; en = e; sload_n = sl; aload_n = al;
    if (!al)          begin mr = FRC; mf = FRC; end
    else if (e && !sl) begin mr = SLV; mf = SLV; end
    else if (e)       begin mr = r;   mf = f;   end
    it.r = mr; it.f = mf; it.tag = tag;
    sb.push_back(it);
    if (!al) begin
      #0.5;
      check({tag, " R3 immediate"}, q_rise[0], q_fall[0], FRC, FRC);
    end
  endtask

  // Monitor: compare each rising-edge result with the queued expectation.
  initial begin
    forever begin
      @(posedge clk); #0.5;
      if (sb.size() > 0) begin
        exp_t it;
        it = sb.pop_front();
        check(it.tag, q_rise[0], q_fall[0], it.r, it.f);
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1 aload_n = 1'b0;
    #0.5;
    check("R3 reset state", q_rise[0], q_fall[0], FRC, FRC);
    mr = FRC; mf = FRC;
    cyc(1, 0, 1, 1, 0, "R6 held load, en high");
    cyc(0, 1, 1, 0, 0, "R6 held load, sync load low");
    cyc(1, 1, 0, 1, 1, "R7 release, en low hold");
    cyc(1, 0, 1, 1, 1, "R7 first capture after release");
    cyc(0, 1, 1, 1, 1, "R1 R2 capture 0/1");
    cyc(1, 1, 1, 1, 1, "R1 R2 capture 1/1");
    cyc(0, 0, 1, 1, 1, "R1 R2 capture 0/0");
    cyc(1, 0, 1, 0, 1, "R4 sync load");
    cyc(1, 1, 0, 0, 1, "R5 sync load ignored when en low");
    cyc(1, 1, 1, 1, 1, "R1 capture after sync load");
    cyc(0, 0, 0, 1, 1, "R5 enable low hold");
    cyc(0, 1, 0, 1, 1, "R5 enable low hold again");
    cyc(0, 1, 1, 1, 1, "R2 falling sample retimed");
    cyc(1, 1, 1, 1, 0, "R3 async load mid-run");
    cyc(0, 0, 1, 1, 1, "R7 capture after second release");
    for (int k = 0; k < 24; k++) begin
      cyc(logic'(k[0] ^ k[2]), logic'(k[1]), logic'(k % 5 != 0),
          logic'(k % 7 != 3), 1'b1, "R1 R2 R4 R5 mixed pattern");
    end
    @(posedge clk); #1;
    @(posedge clk); #1;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule